// File: doc/BRIEF.md
# PRBS Bit-Error Window Counters

This block keeps two small saturating counters that together give software a bit-error rate over a known interval. The low half of a 16-bit readable word counts bit errors flagged by a pseudo-random sequence checker, one per error strobe. The high half counts received CRC multiframe boundaries, one per boundary strobe. The number of errors divided by the number of multiframes gives an error rate over that span.

Software opens a new window with a single write. The write loads the error count with the low byte of the written data, which is normally zero. As a side effect, the same write zeroes the multiframe count, so both halves measure the same interval. Neither half wraps: a count that reaches its top value stays there until the next write or reset. A synchronous, active-high reset clears both halves.

Top module: `prbs_win_ctr`

## Requirements
- R1: While `rst` is high at a rising clock edge, both counters become zero, so `cnt_o` reads 16'h0000 after that edge.
- R2: When `err_i` is high at a rising edge, with no write and the error count below 255, the error count in `cnt_o[7:0]` rises by exactly one.
- R3: When `mf_i` is high at a rising edge, with no write and the multiframe count below 255, the multiframe count in `cnt_o[15:8]` rises by exactly one.
- R4: When `wr_en_i` is high at a rising edge, `cnt_o[7:0]` takes `wr_data_i[7:0]` and `cnt_o[15:8]` becomes zero. The bits `wr_data_i[15:8]` have no effect.
- R5: A write wins over an error strobe and over a multiframe strobe in the same cycle. The result is exactly that of R4, and neither strobe is counted.
- R6: Each counter saturates at 255. A strobe at a count of 255 leaves it at 255.
- R7: An error strobe and a multiframe strobe in the same cycle each advance their own counter by one.
- R8: With no strobe and no write, `cnt_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_i | input | 1 | One-cycle bit-error strobe from the sequence checker |
| mf_i | input | 1 | One-cycle CRC multiframe boundary strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data; only bits 7:0 are used |
| cnt_o | output | 16 | {multiframe count, error count} |

## Verification
Several functions can fall in the same cycle, and the bench provokes each case on purpose.

A register write can coincide with an error strobe, a boundary strobe, or both at once, including while the counters are saturated. In each case the bench expects the written low byte together with a zero multiframe count. Any counted strobe therefore shows up as an off-by-one in the compare that follows.

An error strobe and a boundary strobe are also raised together, both below the limit and at the limit. Here the bench expects each half to move independently, or to stay at 255 once saturated.

// File: rtl/prbs_win_pkg.sv
package prbs_win_pkg;

    // Width of one counter half; the readable word is two halves.
    localparam int CNT_W = 8;
    localparam int REG_W = 2 * CNT_W;

    // Action applied to one counter in a cycle.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_INC   = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } cnt_act_e;

    // Per-cycle command for both halves.
    typedef struct packed {
        cnt_act_e mf_act;
        cnt_act_e err_act;
    } win_cmd_t;

    // Chooses the action for one counter: a write beats its strobe.
    function automatic cnt_act_e pick_act(input logic wr, input logic strobe,
                                          input cnt_act_e wr_act);
        if (wr)
            return wr_act;
        else if (strobe)
            return ACT_INC;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/prbs_win_ctl.sv
module prbs_win_ctl
    import prbs_win_pkg::*;
(
    input  logic     wr_en_i,
    input  logic     err_i,
    input  logic     mf_i,
    output win_cmd_t cmd_o
);

    always_comb begin
        cmd_o.err_act = pick_act(wr_en_i, err_i, ACT_LOAD);
        cmd_o.mf_act  = pick_act(wr_en_i, mf_i, ACT_CLEAR);
    end

endmodule

// File: rtl/prbs_sat_ctr.sv
module prbs_sat_ctr
    import prbs_win_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_act_e     act_i,
    input  logic [W-1:0] load_i,
    output logic [W-1:0] q_o
);

    localparam logic [W-1:0] MAX_V = {W{1'b1}};

    logic [W-1:0] q_r;
    logic         at_max;

    assign at_max = (q_r == MAX_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else begin
            unique case (act_i)
                ACT_INC:   if (!at_max) q_r <= q_r + 1'b1;
                ACT_LOAD:  q_r <= load_i;
                ACT_CLEAR: q_r <= '0;
                default:   q_r <= q_r;
            endcase
        end
    end

    assign q_o = q_r;

endmodule

// File: rtl/prbs_win_ctr.sv
module prbs_win_ctr
    import prbs_win_pkg::*;
#(
    parameter int CW = CNT_W,
    localparam int RW = 2 * CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          err_i,
    input  logic          mf_i,
    input  logic          wr_en_i,
    input  logic [RW-1:0] wr_data_i,
    output logic [RW-1:0] cnt_o
);

    win_cmd_t       cmd;
    logic [CW-1:0]  err_q;
    logic [CW-1:0]  mf_q;
    logic           unused_wr_hi;

    // Upper write bits are deliberately ignored.
    assign unused_wr_hi = ^wr_data_i[RW-1:CW];

    prbs_win_ctl u_ctl (
        .wr_en_i (wr_en_i),
        .err_i   (err_i),
        .mf_i    (mf_i),
        .cmd_o   (cmd)
    );

    prbs_sat_ctr #(.W(CW)) u_err_ctr (
        .clk    (clk),
        .rst    (rst),
        .act_i  (cmd.err_act),
        .load_i (wr_data_i[CW-1:0]),
        .q_o    (err_q)
    );

    // Multiframe half is never loaded; its load input is tied to zero.
    prbs_sat_ctr #(.W(CW)) u_mf_ctr (
        .clk    (clk),
        .rst    (rst),
        .act_i  (cmd.mf_act),
        .load_i ('0),
        .q_o    (mf_q)
    );

    assign cnt_o = {mf_q, err_q};

endmodule

// File: rtl/prbs_win_ctr_chk.sv
module prbs_win_ctr_chk #(
    parameter int CW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            err_i,
    input logic            mf_i,
    input logic            wr_en_i,
    input logic [CW-1:0]   wr_lo_i,
    input logic [2*CW-1:0] cnt_o
);

    localparam logic [CW-1:0] MAX_V = {CW{1'b1}};

    logic past_rst = 1'b0;
    always_ff @(posedge clk) past_rst <= rst;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        past_rst |-> cnt_o == '0); // R1

    AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && err_i && cnt_o[CW-1:0] != MAX_V)
        |=> cnt_o[CW-1:0] == $past(cnt_o[CW-1:0]) + 1'b1); // R2

    AST_MF_STEP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && mf_i && cnt_o[2*CW-1:CW] != MAX_V)
        |=> cnt_o[2*CW-1:CW] == $past(cnt_o[2*CW-1:CW]) + 1'b1); // R3

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> cnt_o == {{CW{1'b0}}, $past(wr_lo_i)}); // R5

    AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && cnt_o[CW-1:0] == MAX_V) |=> cnt_o[CW-1:0] == MAX_V); // R6

    AST_MF_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && cnt_o[2*CW-1:CW] == MAX_V) |=> cnt_o[2*CW-1:CW] == MAX_V); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !err_i && !mf_i) |=> $stable(cnt_o)); // R8

endmodule

bind prbs_win_ctr prbs_win_ctr_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .err_i   (err_i),
    .mf_i    (mf_i),
    .wr_en_i (wr_en_i),
    .wr_lo_i (wr_data_i[CW-1:0]),
    .cnt_o   (cnt_o)
);

// File: tb/tb_prbs_win_ctr.sv
module tb_prbs_win_ctr;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_i = 1'b0;
    logic        mf_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = 16'h0;
    logic [15:0] cnt_o;

    item_t q[$];
    int    n_chk = 0;
    int    n_err = 0;
    int    m_err = 0;
    int    m_mf = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    prbs_win_ctr dut (
        .clk       (clk),
        .rst       (rst),
        .err_i     (err_i),
        .mf_i      (mf_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cnt_o     (cnt_o)
    );

    // Driver: one call per clock; model follows the requirements.
    task automatic step(input bit r, input bit e, input bit m, input bit w,
                        input logic [15:0] d, input string tag);
        item_t it;
        @(negedge clk);
        rst = r; err_i = e; mf_i = m; wr_en_i = w; wr_data_i = d;
        if (r) begin
            m_err = 0; m_mf = 0;
        end else if (w) begin
            m_err = int'(d[7:0]); m_mf = 0;
        end else begin
            if (e && m_err < 255) m_err++;
            if (m && m_mf < 255) m_mf++;
        end
        it.exp = {m_mf[7:0], m_err[7:0]};
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compares halfway between the capturing edge and the next drive.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (cnt_o !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: cnt_o=%h expected=%h", it.tag, cnt_o, it.exp);
                end
            end
        end
    end

    initial begin
        step(1, 0, 0, 0, 16'h0, "R1 reset");
        step(1, 1, 1, 1, 16'h00FF, "R1 reset beats all");
        repeat (5) step(0, 1, 0, 0, 16'h0, "R2 error count");
        repeat (3) step(0, 0, 1, 0, 16'h0, "R3 multiframe count");
        repeat (4) step(0, 1, 1, 0, 16'h0, "R7 both strobes");
        repeat (3) step(0, 0, 0, 0, 16'hFFFF, "R8 idle hold");
        step(0, 0, 0, 1, 16'hAB5C, "R4 write load, high byte ignored");
        repeat (2) step(0, 0, 1, 0, 16'h0, "R3 after write");
        step(0, 1, 0, 1, 16'h0011, "R5 write beats error");
        step(0, 0, 1, 1, 16'h0022, "R5 write beats multiframe");
        step(0, 1, 1, 1, 16'h0000, "R5 write beats both");
        repeat (260) step(0, 1, 0, 0, 16'h0, "R6 error saturate");
        repeat (260) step(0, 0, 1, 0, 16'h0, "R6 multiframe saturate");
        repeat (3) step(0, 1, 1, 0, 16'h0, "R6 R7 both at limit");
        step(0, 1, 1, 1, 16'h00FE, "R5 write at limit");
        step(0, 1, 0, 0, 16'h0, "R6 one below limit");
        step(0, 1, 0, 0, 16'h0, "R6 at limit");
        step(0, 0, 0, 0, 16'h0, "R8 idle at limit");
        repeat (6) step(0, 1, 1, 0, 16'h0, "R7 both again");
        step(1, 0, 0, 0, 16'h0, "R1 reset mid count");
        step(0, 0, 0, 0, 16'h0, "R8 idle after reset");
        step(0, 0, 0, 0, 16'h0, "R8 idle after reset");
        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: cnt_o=%h expected=completion", cnt_o);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule